// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block vets one segmented memory access per cycle for a processor core that runs outside its 64-bit mode. It takes the segment the access goes through (index, null-selector flag, attribute bits, base, limit), the effective address, the access length in bytes and the kind of access. It reports whether the access must raise a general-protection fault. Alongside the verdict it returns the offset into the segment, wrapped to the selected address width, and the linear address handed to paging, cut to 32 bits when the core is not in its 64-bit submode or when an address-size override is present.

The checks are pure combinational logic. A single register stage holds the verdict, the offset and the linear address. A check-enable input lets the surrounding pipeline bypass the protection logic, as it does in long mode. When the enable is low the fault output stays low, while the offset and linear address are still produced.

Top module: `seg_guard`

## Requirements
- R1: While `rst` is high at a rising edge, `fault`, `seg_off` and `lin_addr` are cleared to zero on that edge.
- R2: When `chk_en` is low, `fault` is low; `seg_off` and `lin_addr` are still computed as in R6 and R9.
- R3: With `sel_null` high, the access faults unless `seg_idx` is one of the exempt indices 6, 8, 10 or 11.
- R4: For `seg_idx` 0 to 6, an access of kind write (`acc_kind` 1) or store-probe (`acc_kind` 2) to a segment with `attr_wr` low faults.
- R5: For `seg_idx` 0 to 6, an access of kind read (`acc_kind` 0) or store-probe (`acc_kind` 2) to a segment with `attr_rd` low faults. A fetch (`acc_kind` 3) is never faulted by the attribute bits, and indices 7 and above skip the attribute checks.
- R6: The address width is 8 shifted left by a 2-bit log, which gives 8, 16, 32 or 64 bits. The log is taken from `log_alt` when `ovr` is high and from `log_def` otherwise. `seg_off` is (`eff_addr` - `seg_base`) modulo 2 to the power of that width.
- R7: For a segment that is not expand-down, the access faults when the offset or the end offset is above `seg_limit`. The end offset is the offset plus `acc_size` minus one, is computed without truncation, and treats a size of zero as one byte.
- R8: For an expand-down segment (`attr_xd` high with `seg_idx` 0 to 6), the access faults when the offset or the end offset is less than or equal to `seg_limit`. For any other index, `attr_xd` has no effect and R7 applies.
- R9: `lin_addr` equals `eff_addr` with bits 32 and up cleared when `sub64` is low or `ovr` is high, and equals `eff_addr` unchanged otherwise.
- R10: All three outputs are registered. Each reflects the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Enable for the protection checks; low bypasses them |
| seg_idx | input | 4 | Segment index |
| sel_null | input | 1 | The segment's selector is null |
| attr_rd | input | 1 | Segment is readable |
| attr_wr | input | 1 | Segment is writable |
| attr_xd | input | 1 | Segment expands downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| eff_addr | input | ADDR_W | Effective address of the access |
| acc_size | input | SIZE_W | Access length in bytes |
| acc_kind | input | 2 | 0 read, 1 write, 2 store-probe, 3 fetch |
| ovr | input | 1 | Address-size override |
| log_def | input | 2 | Default address-width log |
| log_alt | input | 2 | Alternate address-width log |
| sub64 | input | 1 | Core is in its 64-bit submode |
| fault | output | 1 | General-protection fault for this access |
| seg_off | output | ADDR_W | Offset into the segment, wrapped to the address width |
| lin_addr | output | ADDR_W | Linear address after width masking |

## Verification
Every result of the block (the fault bit, the wrapped offset and the masked linear address) is due exactly one rising edge after its inputs are presented. There is no other latency in the design. The bench changes the inputs at a falling edge and samples all three outputs at the next falling edge, half a period after the capturing edge, so each vector is judged against the inputs that produced it. The reset vector is driven with inputs that would fault and is checked at the same point, to show that the clear overrides the logic.

// File: rtl/segchk_pkg.sv
package segchk_pkg;

    localparam int IDX_W = 4;

    // Kinds of access presented to the checker
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_PROBE = 2'd2,   // read that must also be legal as a write
        ACC_FETCH = 2'd3
    } acc_kind_e;

    // Descriptor attribute bits
    typedef struct packed {
        logic rd;
        logic wr;
        logic xd;
    } seg_attr_t;

    // Partial fault causes gathered from the sub-checks
    typedef struct packed {
        logic null_f;
        logic perm_f;
        logic lim_f;
    } fault_vec_t;

    // Index map: 0..5 program segments, 6 hidden scratch segment,
    // 7 local table, 8 task, 9 global table, 10 interrupt table, 11 loader
    localparam logic [IDX_W-1:0] SEG_LAST_PROG = 4'd6;
    localparam logic [IDX_W-1:0] SEG_SCRATCH   = 4'd6;
    localparam logic [IDX_W-1:0] SEG_TASK      = 4'd8;
    localparam logic [IDX_W-1:0] SEG_INT_TBL   = 4'd10;
    localparam logic [IDX_W-1:0] SEG_LOADER    = 4'd11;

    function automatic logic null_exempt(input logic [IDX_W-1:0] idx);
        return (idx == SEG_SCRATCH) || (idx == SEG_TASK) ||
               (idx == SEG_INT_TBL) || (idx == SEG_LOADER);
    endfunction

    function automatic logic attr_checked(input logic [IDX_W-1:0] idx);
        return idx <= SEG_LAST_PROG;
    endfunction

    function automatic logic needs_write(input acc_kind_e k);
        return (k == ACC_WRITE) || (k == ACC_PROBE);
    endfunction

    function automatic logic needs_read(input acc_kind_e k);
        return (k == ACC_READ) || (k == ACC_PROBE);
    endfunction

endpackage

// File: rtl/seg_perm_check.sv
module seg_perm_check
    import segchk_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             sel_null,
    input  seg_attr_t        attr,
    input  acc_kind_e        kind,
    output logic             null_f,
    output logic             perm_f,
    output logic             xd_eff
);
    logic prog_seg;
    logic wr_bad;
    logic rd_bad;

    always_comb begin
        prog_seg = attr_checked(idx);
        null_f   = sel_null && !null_exempt(idx);
        wr_bad   = needs_write(kind) && !attr.wr;
        rd_bad   = needs_read(kind) && !attr.rd;
        perm_f   = prog_seg && (wr_bad || rd_bad);
        xd_eff   = prog_seg && attr.xd;
    end
endmodule

// File: rtl/seg_offset_calc.sv
module seg_offset_calc #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [1:0]        log_sel,
    input  logic [SIZE_W-1:0] acc_size,
    output logic [ADDR_W-1:0] off,
    output logic [ADDR_W:0]   end_off
);
    localparam int EXT_W = ADDR_W + 1;

    logic [7:0]        nbits;
    logic [ADDR_W-1:0] wmask;
    logic [ADDR_W-1:0] diff;
    logic [SIZE_W-1:0] span;

    assign nbits = 8'd8 << log_sel;

    // Bit g survives when it lies below the selected width
    for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
        assign wmask[g] = (g < int'(nbits));
    end

    always_comb begin
        diff    = eff_addr - seg_base;
        off     = diff & wmask;
        span    = (acc_size == '0) ? '0 : (acc_size - 1'b1);
        end_off = {1'b0, off} + EXT_W'(span);
    end
endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] off,
    input  logic [ADDR_W:0]   end_off,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              xd_eff,
    output logic              lim_f
);
    logic first_above;
    logic last_above;

    always_comb begin
        first_above = off > seg_limit;
        last_above  = end_off > {1'b0, seg_limit};
        if (xd_eff) begin
            lim_f = !first_above || !last_above;
        end else begin
            lim_f = first_above || last_above;
        end
    end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import segchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic [3:0]        seg_idx,
    input  logic              sel_null,
    input  logic              attr_rd,
    input  logic              attr_wr,
    input  logic              attr_xd,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [1:0]        acc_kind,
    input  logic              ovr,
    input  logic [1:0]        log_def,
    input  logic [1:0]        log_alt,
    input  logic              sub64,
    output logic              fault,
    output logic [ADDR_W-1:0] seg_off,
    output logic [ADDR_W-1:0] lin_addr
);
    localparam int LIN_KEEP = (ADDR_W < 32) ? ADDR_W : 32;

    seg_attr_t         attr;
    acc_kind_e         kind;
    fault_vec_t        causes;
    logic              xd_eff;
    logic [1:0]        log_sel;
    logic [ADDR_W-1:0] off_c;
    logic [ADDR_W:0]   end_c;
    logic [ADDR_W-1:0] lin_c;
    logic              fault_c;
    logic              cut32;

    assign attr    = '{rd: attr_rd, wr: attr_wr, xd: attr_xd};
    assign kind    = acc_kind_e'(acc_kind);
    assign log_sel = ovr ? log_alt : log_def;
    assign cut32   = !sub64 || ovr;

    seg_perm_check u_perm (
        .idx      (seg_idx),
        .sel_null (sel_null),
        .attr     (attr),
        .kind     (kind),
        .null_f   (causes.null_f),
        .perm_f   (causes.perm_f),
        .xd_eff   (xd_eff)
    );

    seg_offset_calc #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_off (
        .eff_addr (eff_addr),
        .seg_base (seg_base),
        .log_sel  (log_sel),
        .acc_size (acc_size),
        .off      (off_c),
        .end_off  (end_c)
    );

    seg_limit_cmp #(
        .ADDR_W (ADDR_W)
    ) u_lim (
        .off       (off_c),
        .end_off   (end_c),
        .seg_limit (seg_limit),
        .xd_eff    (xd_eff),
        .lim_f     (causes.lim_f)
    );

    // Width cut for the linear address
    if (ADDR_W > 32) begin : g_wide
        assign lin_c = cut32 ? {{(ADDR_W-LIN_KEEP){1'b0}}, eff_addr[LIN_KEEP-1:0]}
                             : eff_addr;
    end else begin : g_narrow
        assign lin_c = eff_addr;
    end

    assign fault_c = chk_en && (|causes);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault    <= 1'b0;
            seg_off  <= '0;
            lin_addr <= '0;
        end else begin
            fault    <= fault_c;
            seg_off  <= off_c;
            lin_addr <= lin_c;
        end
    end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk
    import segchk_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              chk_en,
    input logic [3:0]        seg_idx,
    input logic              sel_null,
    input logic              attr_rd,
    input logic              attr_wr,
    input logic              attr_xd,
    input logic [ADDR_W-1:0] seg_limit,
    input logic [1:0]        acc_kind,
    input logic              ovr,
    input logic              sub64,
    input logic              fault,
    input logic [ADDR_W-1:0] seg_off
);
    // R2: bypassed checks never fault
    a_r2_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> !fault);

    // R3: null selector on a non-exempt segment
    a_r3_null_sel: assert property (@(posedge clk) disable iff (rst)
        (chk_en && sel_null && !null_exempt(seg_idx)) |=> fault);

    // R4: store to a read-only program segment
    a_r4_no_write: assert property (@(posedge clk) disable iff (rst)
        (chk_en && attr_checked(seg_idx) && !attr_wr &&
         needs_write(acc_kind_e'(acc_kind))) |=> fault);

    // R5: read of an execute-only program segment
    a_r5_no_read: assert property (@(posedge clk) disable iff (rst)
        (chk_en && attr_checked(seg_idx) && !attr_rd &&
         needs_read(acc_kind_e'(acc_kind))) |=> fault);

    // R7: a passing upward segment access starts within the limit
    a_r7_within_limit: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !(attr_xd && attr_checked(seg_idx))) |=>
            (fault || (seg_off <= $past(seg_limit))));

    // R8: a passing expand-down access starts above the limit
    a_r8_above_limit: assert property (@(posedge clk) disable iff (rst)
        (chk_en && attr_xd && attr_checked(seg_idx)) |=>
            (fault || (seg_off > $past(seg_limit))));

    // R9: upper address bits cleared outside the 64-bit submode
    if (ADDR_W > 32) begin : g_cut
        a_r9_cut32: assert property (@(posedge clk) disable iff (rst)
            (!sub64 || ovr) |=> (seg_guard.lin_addr[ADDR_W-1:32] == '0));
    end
endmodule

bind seg_guard seg_guard_chk #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
) u_seg_guard_chk (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (chk_en),
    .seg_idx   (seg_idx),
    .sel_null  (sel_null),
    .attr_rd   (attr_rd),
    .attr_wr   (attr_wr),
    .attr_xd   (attr_xd),
    .seg_limit (seg_limit),
    .acc_kind  (acc_kind),
    .ovr       (ovr),
    .sub64     (sub64),
    .fault     (fault),
    .seg_off   (seg_off)
);

// File: tb/test_seg_guard.sv
module test_seg_guard;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 64;
    localparam int SIZE_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              chk_en;
    logic [3:0]        seg_idx;
    logic              sel_null, attr_rd, attr_wr, attr_xd;
    logic [ADDR_W-1:0] seg_base, seg_limit, eff_addr;
    logic [SIZE_W-1:0] acc_size;
    logic [1:0]        acc_kind;
    logic              ovr;
    logic [1:0]        log_def, log_alt;
    logic              sub64;
    logic              fault;
    logic [ADDR_W-1:0] seg_off, lin_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    seg_guard #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_seg_guard (
        .clk(clk), .rst(rst), .chk_en(chk_en), .seg_idx(seg_idx),
        .sel_null(sel_null), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .attr_xd(attr_xd), .seg_base(seg_base), .seg_limit(seg_limit),
        .eff_addr(eff_addr), .acc_size(acc_size), .acc_kind(acc_kind),
        .ovr(ovr), .log_def(log_def), .log_alt(log_alt), .sub64(sub64),
        .fault(fault), .seg_off(seg_off), .lin_addr(lin_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic reference for one vector
    task automatic expect_vec(output bit f, output logic [63:0] off, output logic [63:0] lin);
        int unsigned    lg;
        int unsigned    nb;
        logic [63:0]    d;
        logic [64:0]    e;
        int unsigned    sz;
        bit             prog, xd, lim_bad;
        lg   = ovr ? log_alt : log_def;
        nb   = 8 << lg;
        d    = eff_addr - seg_base;
        off  = (nb >= 64) ? d : (d % (64'd1 << nb));
        sz   = (acc_size == 0) ? 1 : acc_size;
        e    = {1'b0, off} + 65'(sz) - 65'd1;
        prog = seg_idx <= 6;
        xd   = prog && attr_xd;
        if (xd) lim_bad = (off <= seg_limit) || (e <= {1'b0, seg_limit});
        else    lim_bad = (off > seg_limit) || (e > {1'b0, seg_limit});
        f = chk_en && (
              (sel_null && !(seg_idx inside {4'd6, 4'd8, 4'd10, 4'd11})) ||
              (prog && !attr_wr && (acc_kind == 2'd1 || acc_kind == 2'd2)) ||
              (prog && !attr_rd && (acc_kind == 2'd0 || acc_kind == 2'd2)) ||
              lim_bad);
        lin = (!sub64 || ovr) ? {32'd0, eff_addr[31:0]} : eff_addr;
    endtask

    // Inputs were set just after a falling edge; result due one rising edge later
    task automatic step(input string tag);
        bit          f;
        logic [63:0] o, l;
        expect_vec(f, o, l);
        @(negedge clk);
        chk({tag, " fault"}, {63'd0, fault}, {63'd0, f});
        chk({tag, " R6 seg_off"}, seg_off, o);
        chk({tag, " R9 lin_addr"}, lin_addr, l);
    endtask

    task automatic defaults();
        chk_en = 1; seg_idx = 3; sel_null = 0; attr_rd = 1; attr_wr = 1; attr_xd = 0;
        seg_base = 0; seg_limit = 64'hFFFF; eff_addr = 64'h100; acc_size = 4;
        acc_kind = 0; ovr = 0; log_def = 2; log_alt = 1; sub64 = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        defaults();
        rst = 1; sel_null = 1; eff_addr = 64'hFFFF_FFFF_0001_2345; sub64 = 1;
        @(negedge clk); @(negedge clk);
        // R1: cleared during reset even with faulting inputs
        chk("R1 fault", {63'd0, fault}, 64'd0);
        chk("R1 seg_off", seg_off, 64'd0);
        chk("R1 lin_addr", lin_addr, 64'd0);
        rst = 0;
        defaults();
        step("R10 first");

        // R2 R3 R4 R5: index x null x attributes x kind x enable
        for (int en = 0; en < 2; en++)
            for (int i = 0; i < 12; i++)
                for (int n = 0; n < 2; n++)
                    for (int a = 0; a < 4; a++)
                        for (int k = 0; k < 4; k++) begin
                            defaults();
                            chk_en = en[0]; seg_idx = 4'(i); sel_null = n[0];
                            attr_rd = a[0]; attr_wr = a[1]; acc_kind = 2'(k);
                            step("R2 R3 R4 R5 perm");
                        end

        // R6 R7 R8: offsets around the limit, every width, both directions
        for (int lg = 0; lg < 4; lg++)
            for (int ov = 0; ov < 2; ov++)
                for (int xd = 0; xd < 2; xd++)
                    for (int d = -8; d <= 8; d++)
                        for (int s = 0; s <= 8; s++) begin
                            defaults();
                            ovr = ov[0];
                            if (ov != 0) begin log_alt = 2'(lg); log_def = 2'(3 - lg); end
                            else         begin log_def = 2'(lg); log_alt = 2'(3 - lg); end
                            attr_xd = xd[0]; seg_idx = (s == 8) ? 4'd7 : 4'd3;
                            seg_base = 64'h1000; seg_limit = 64'h80;
                            eff_addr = 64'h1080 + 64'(d); acc_size = 4'(s);
                            step("R6 R7 R8 limit");
                        end

        // R6 R9: wrapping offsets and address cut with scattered values
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int v = 0; v < 40; v++)
            for (int m = 0; m < 4; m++) begin
                x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
                defaults();
                eff_addr = x; seg_base = {x[31:0], x[63:32]};
                seg_limit = {32'd0, x[47:16]}; acc_size = 4'(x[3:0]);
                log_def = x[5:4]; log_alt = x[7:6]; ovr = m[0]; sub64 = m[1];
                attr_xd = x[8];
                step("R6 R7 R8 R9 wrap");
            end

        // R8: expand-down with maximal limit always faults, top of space
        defaults();
        attr_xd = 1; seg_limit = '1; eff_addr = '1; log_def = 3; sub64 = 1;
        step("R8 xd max");
        // R7: end offset crosses the 64-bit top without wrapping
        defaults();
        seg_limit = '1; eff_addr = 64'hFFFF_FFFF_FFFF_FFFE; acc_size = 4;
        log_def = 3; sub64 = 1;
        step("R7 carry");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule